// File: doc/BRIEF.md
# Privilege-Gated Processor Status Word

This block holds the status flags of a 32-bit processor core and presents them as one architectural word. The word is always visible on a read output that is assembled from the stored flags. Bit 1 of that word is tied to one, and every position that holds no flag reads as zero.

Two write strobes load flags from a data word. A full write covers all 32 bits, and a lower-word write covers only bits 15:0. Some fields accept a write only when the current privilege level of the core (0 is most privileged, 3 is least) allows it. The interrupt-enable flag needs the privilege level to be at or below the stored I/O privilege field. The I/O privilege field and the virtual-mode flag need privilege level 0. A separate update path changes only the overflow flag after a multi-bit shift or rotate. A mode input selects whether it copies the last-step overflow or forces a fixed "undefined" constant. An optional alignment-check flag is present only when a parameter enables it.

Top module: `psw_gate_reg`

## Requirements
- R1: After reset the read word is 0x00000002.
- R2: Bit 1 of the read word is always 1. Bits 3, 5, 15 and 31:19 are always 0.
- R3: The flags at bit positions 0 (carry), 2 (parity), 4 (aux carry), 6 (zero), 7 (sign), 8 (trap), 10 (direction), 11 (overflow) and 14 (nested task) take the matching data bits on any full or lower-word write, whatever the privilege level. With no strobe active, the read word holds its value.
- R4: Interrupt-enable (bit 9) is written only when the privilege input is less than or equal to the I/O privilege field held before the write.
- R5: The I/O privilege field (bits 13:12) is written only when the privilege input is 0.
- R6: On a full write, resume (bit 16) is always written. Virtual-mode (bit 17) is written only when the privilege input is 0.
- R7: A lower-word write alone leaves bits 18:16 unchanged.
- R8: Alignment-check (bit 18) is written by a full write when the parameter HAS_AC is 1. When HAS_AC is 0 it reads as 0 and ignores writes.
- R9: An overflow update with mode 0 sets bit 11 to the supplied overflow value.
- R10: An overflow update with mode 1 sets bit 11 to the parameter UNDEF_OF.
- R11: An overflow update changes no bit other than bit 11.
- R12: When a write and an overflow update arrive in the same cycle, bit 11 follows the overflow update. When both write strobes are active, the full-write rules apply.
- R13: All fields updated by one strobe change on the same clock edge, and the new value is visible on the read word in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_cpl | input | 2 | Current privilege level of the core |
| wr_full | input | 1 | Full 32-bit write strobe |
| wr_low | input | 1 | Lower 16-bit write strobe |
| wr_data | input | 32 | Data word for either write |
| ovf_upd | input | 1 | Shift/rotate overflow update strobe |
| ovf_mode | input | 1 | 0: copy ovf_val, 1: force UNDEF_OF |
| ovf_val | input | 1 | Overflow from the last shift/rotate step |
| flag_word | output | 32 | Assembled status word |

## Verification
The bench drives two copies of the block with identical stimulus. One uses HAS_AC=1 and UNDEF_OF=0. The other uses HAS_AC=0 and UNDEF_OF=1. With this pair, the alignment-check bit can be seen both as a stored flag and as a tied-off zero. It also means the forced-overflow mode gives a result that differs from the previous overflow in both directions. Directed vectors cover each privilege gate at the boundary where the privilege level equals the stored I/O field. A seeded pseudo-random stream then mixes strobes, privilege levels and data across both copies.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int WORD_W = 32;
  localparam int CPL_W  = 2;

  localparam int P_CF   = 0;
  localparam int P_ONE  = 1;
  localparam int P_PF   = 2;
  localparam int P_AF   = 4;
  localparam int P_ZF   = 6;
  localparam int P_SF   = 7;
  localparam int P_TF   = 8;
  localparam int P_IE   = 9;
  localparam int P_DF   = 10;
  localparam int P_OF   = 11;
  localparam int P_IOPL = 12;
  localparam int P_NT   = 14;
  localparam int P_RF   = 16;
  localparam int P_VM   = 17;
  localparam int P_AC   = 18;

  typedef struct packed {
    logic             cf;
    logic             pf;
    logic             af;
    logic             zf;
    logic             sf;
    logic             tf;
    logic             ie;
    logic             df;
    logic             of;
    logic [CPL_W-1:0] iopl;
    logic             nt;
    logic             rf;
    logic             vm;
    logic             ac;
  } psw_t;

  // Interrupt-enable gate: privilege must be numerically at or below IOPL.
  function automatic logic ie_allowed(input logic [CPL_W-1:0] cpl,
                                      input logic [CPL_W-1:0] iopl);
    return (cpl <= iopl);
  endfunction

  // Gate for fields reserved to the most privileged level.
  function automatic logic top_level(input logic [CPL_W-1:0] cpl);
    return (cpl == '0);
  endfunction

  // Fields written unconditionally from the low half of the data word.
  function automatic psw_t load_free(input psw_t s,
                                     input logic [WORD_W-1:0] d);
    psw_t r;
    r    = s;
    r.cf = d[P_CF];
    r.pf = d[P_PF];
    r.af = d[P_AF];
    r.zf = d[P_ZF];
    r.sf = d[P_SF];
    r.tf = d[P_TF];
    r.df = d[P_DF];
    r.of = d[P_OF];
    r.nt = d[P_NT];
    return r;
  endfunction

  // Build the architectural word from stored fields.
  function automatic logic [WORD_W-1:0] pack_word(input psw_t s,
                                                  input logic ac_bit);
    logic [WORD_W-1:0] w;
    w                        = '0;
    w[P_CF]                  = s.cf;
    w[P_ONE]                 = 1'b1;
    w[P_PF]                  = s.pf;
    w[P_AF]                  = s.af;
    w[P_ZF]                  = s.zf;
    w[P_SF]                  = s.sf;
    w[P_TF]                  = s.tf;
    w[P_IE]                  = s.ie;
    w[P_DF]                  = s.df;
    w[P_OF]                  = s.of;
    w[P_IOPL+CPL_W-1:P_IOPL] = s.iopl;
    w[P_NT]                  = s.nt;
    w[P_RF]                  = s.rf;
    w[P_VM]                  = s.vm;
    w[P_AC]                  = ac_bit;
    return w;
  endfunction

endpackage

// File: rtl/psw_priv_gate.sv
module psw_priv_gate
  import psw_pkg::*;
#(
  parameter bit HAS_AC = 1'b1
) (
  input  logic [CPL_W-1:0] cpl,
  input  logic [CPL_W-1:0] iopl_cur,
  input  logic             wr_full,
  input  logic             wr_low,
  output logic             wr_any,
  output logic             ie_ok,
  output logic             iopl_ok,
  output logic             rf_ok,
  output logic             vm_ok,
  output logic             ac_ok
);

  assign wr_any  = wr_full | wr_low;
  assign ie_ok   = wr_any  & ie_allowed(cpl, iopl_cur);
  assign iopl_ok = wr_any  & top_level(cpl);
  assign rf_ok   = wr_full;
  assign vm_ok   = wr_full & top_level(cpl);

  generate
    if (HAS_AC) begin : g_ac
      assign ac_ok = wr_full;
    end else begin : g_no_ac
      assign ac_ok = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/psw_ovf_policy.sv
module psw_ovf_policy #(
  parameter bit UNDEF_OF = 1'b0
) (
  input  logic upd,
  input  logic mode,
  input  logic val,
  output logic of_we,
  output logic of_bit
);

  assign of_we  = upd;
  assign of_bit = mode ? UNDEF_OF : val;

endmodule

// File: rtl/psw_word_pack.sv
module psw_word_pack
  import psw_pkg::*;
#(
  parameter bit HAS_AC = 1'b1
) (
  input  psw_t              st,
  output logic [WORD_W-1:0] word
);

  logic ac_vis;

  generate
    if (HAS_AC) begin : g_ac
      assign ac_vis = st.ac;
    end else begin : g_no_ac
      assign ac_vis = 1'b0;
    end
  endgenerate

  assign word = pack_word(st, ac_vis);

endmodule

// File: rtl/psw_gate_reg.sv
module psw_gate_reg
  import psw_pkg::*;
#(
  parameter bit HAS_AC   = 1'b1,
  parameter bit UNDEF_OF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPL_W-1:0]  cur_cpl,
  input  logic              wr_full,
  input  logic              wr_low,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ovf_upd,
  input  logic              ovf_mode,
  input  logic              ovf_val,
  output logic [WORD_W-1:0] flag_word
);

  psw_t flag_q;
  psw_t flag_d;

  // Named events for the checker.
  logic wr_any;
  logic ie_ok;
  logic iopl_ok;
  logic rf_ok;
  logic vm_ok;
  logic ac_ok;
  logic of_we;
  logic of_bit;

  psw_priv_gate #(.HAS_AC(HAS_AC)) u_gate (
    .cpl      (cur_cpl),
    .iopl_cur (flag_q.iopl),
    .wr_full  (wr_full),
    .wr_low   (wr_low),
    .wr_any   (wr_any),
    .ie_ok    (ie_ok),
    .iopl_ok  (iopl_ok),
    .rf_ok    (rf_ok),
    .vm_ok    (vm_ok),
    .ac_ok    (ac_ok)
  );

  psw_ovf_policy #(.UNDEF_OF(UNDEF_OF)) u_ovf (
    .upd    (ovf_upd),
    .mode   (ovf_mode),
    .val    (ovf_val),
    .of_we  (of_we),
    .of_bit (of_bit)
  );

  // All gates look at the stored IOPL, so every field moves on one edge.
  always_comb begin
    flag_d = flag_q;
    if (wr_any)  flag_d = load_free(flag_q, wr_data);
    if (ie_ok)   flag_d.ie   = wr_data[P_IE];
    if (iopl_ok) flag_d.iopl = wr_data[P_IOPL+CPL_W-1:P_IOPL];
    if (rf_ok)   flag_d.rf   = wr_data[P_RF];
    if (vm_ok)   flag_d.vm   = wr_data[P_VM];
    if (ac_ok)   flag_d.ac   = wr_data[P_AC];
    if (of_we)   flag_d.of   = of_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  psw_word_pack #(.HAS_AC(HAS_AC)) u_pack (
    .st   (flag_q),
    .word (flag_word)
  );

endmodule

// File: rtl/psw_gate_reg_chk.sv
module psw_gate_reg_chk
  import psw_pkg::*;
#(
  parameter bit HAS_AC   = 1'b1,
  parameter bit UNDEF_OF = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CPL_W-1:0]  cur_cpl,
  input logic              wr_full,
  input logic              wr_low,
  input logic              ovf_upd,
  input logic              ovf_mode,
  input logic              ovf_val,
  input logic              wr_any,
  input logic              ie_ok,
  input logic [WORD_W-1:0] flag_word
);

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[1] && !flag_word[3] && !flag_word[5] && !flag_word[15]
    && (flag_word[31:19] == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_full || wr_low || ovf_upd) |=> $stable(flag_word));

  assert_ie_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cpl > flag_word[13:12]) |=> $stable(flag_word[9]));

  assert_ie_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ie_ok |-> wr_any);

  assert_iopl_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cpl != 2'd0) |=> $stable(flag_word[13:12]));

  assert_vm_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_full && cur_cpl == 2'd0) |=> $stable(flag_word[17]));

  assert_low_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_low && !wr_full) |=> $stable(flag_word[18:16]));

  assert_ovf_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_upd && !ovf_mode) |=> (flag_word[11] == $past(ovf_val)));

  assert_ovf_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_upd && ovf_mode) |=> (flag_word[11] == UNDEF_OF));

  assert_ovf_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_upd && !wr_full && !wr_low) |=> ($stable(flag_word[10:0])
      && $stable(flag_word[31:12])));

  generate
    if (!HAS_AC) begin : g_no_ac
      assert_ac_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_word[18]);
    end
  endgenerate

endmodule

bind psw_gate_reg psw_gate_reg_chk #(.HAS_AC(HAS_AC), .UNDEF_OF(UNDEF_OF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cur_cpl   (cur_cpl),
  .wr_full   (wr_full),
  .wr_low    (wr_low),
  .ovf_upd   (ovf_upd),
  .ovf_mode  (ovf_mode),
  .ovf_val   (ovf_val),
  .wr_any    (wr_any),
  .ie_ok     (ie_ok),
  .flag_word (flag_word)
);

// File: tb/psw_gate_reg_test.sv
module psw_gate_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cur_cpl = '0;
  logic        wr_full = 1'b0;
  logic        wr_low = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ovf_upd = 1'b0;
  logic        ovf_mode = 1'b0;
  logic        ovf_val = 1'b0;
  logic [31:0] word_a;
  logic [31:0] word_b;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] ea;
    logic [31:0] eb;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] ma = 32'h2;
  logic [31:0] mb = 32'h2;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #5 clk = ~clk;

  psw_gate_reg #(.HAS_AC(1'b1), .UNDEF_OF(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cur_cpl(cur_cpl), .wr_full(wr_full),
    .wr_low(wr_low), .wr_data(wr_data), .ovf_upd(ovf_upd),
    .ovf_mode(ovf_mode), .ovf_val(ovf_val), .flag_word(word_a)
  );

  psw_gate_reg #(.HAS_AC(1'b0), .UNDEF_OF(1'b1)) uut_b (
    .clk(clk), .rst_n(rst_n), .cur_cpl(cur_cpl), .wr_full(wr_full),
    .wr_low(wr_low), .wr_data(wr_data), .ovf_upd(ovf_upd),
    .ovf_mode(ovf_mode), .ovf_val(ovf_val), .flag_word(word_b)
  );

  // Reference model written from the requirements as mask arithmetic.
  function automatic logic [31:0] model(input logic [31:0] o, input logic [1:0] c,
      input logic f, input logic l, input logic [31:0] d, input logic ou,
      input logic om, input logic ov, input bit ac_on, input bit undefv);
    logic [31:0] n;
    logic [31:0] free_mask;
    free_mask = 32'h0000_4DD5;
    n = o;
    if (f || l) begin
      n = (n & ~free_mask) | (d & free_mask);
      if (c <= o[13:12]) n[9] = d[9];
      if (c == 2'd0) n[13:12] = d[13:12];
    end
    if (f) begin
      n[16] = d[16];
      if (c == 2'd0) n[17] = d[17];
      if (ac_on) n[18] = d[18];
    end
    if (ou) n[11] = om ? undefv : ov;
    n[1] = 1'b1;
    return n;
  endfunction

  task automatic check(input string tag, input string which,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s): got 0x%08h expected 0x%08h", tag, which, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] c, input logic f,
                       input logic l, input logic [31:0] d, input logic ou,
                       input logic om, input logic ov);
    exp_t e;
    @(negedge clk);
    cur_cpl = c; wr_full = f; wr_low = l; wr_data = d;
    ovf_upd = ou; ovf_mode = om; ovf_val = ov;
    ma = model(ma, c, f, l, d, ou, om, ov, 1'b1, 1'b0);
    mb = model(mb, c, f, l, d, ou, om, ov, 1'b0, 1'b1);
    e.ea = ma; e.eb = mb; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares one cycle after each driven edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(e.tag, "ac_on", word_a, e.ea);
        check(e.tag, "ac_off", word_b, e.eb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", "ac_on", word_a, 32'h2);
    check("R1 reset", "ac_off", word_b, 32'h2);

    // R2 R3 R6 R8: everything set at privilege 0
    apply("R2 R3 R6 R8 full ones cpl0", 2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    apply("R3 full zero cpl0", 2'd0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    apply("R3 idle hold", 2'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    // IOPL=1, IE=1
    apply("R5 iopl set cpl0", 2'd0, 1'b1, 1'b0, 32'h0000_1200, 1'b0, 1'b0, 1'b0);
    // R4: cpl 2 > iopl 1, IE held; R5 IOPL held; R6 VM held, RF written
    apply("R4 R5 R6 gated cpl2", 2'd2, 1'b1, 1'b0, 32'h0007_3000, 1'b0, 1'b0, 1'b0);
    // R4 boundary: cpl 1 == iopl 1, IE cleared
    apply("R4 equal boundary", 2'd1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    apply("R4 set at boundary", 2'd1, 1'b0, 1'b1, 32'h0000_0200, 1'b0, 1'b0, 1'b0);
    // set RF/VM/AC then low write must keep them
    apply("R6 R8 upper set", 2'd0, 1'b1, 1'b0, 32'h0007_1000, 1'b0, 1'b0, 1'b0);
    apply("R7 low write keeps upper", 2'd0, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
    apply("R7 low write zero", 2'd0, 1'b0, 1'b1, 32'hFFF8_0000, 1'b0, 1'b0, 1'b0);
    // overflow path
    apply("R9 R11 copy one", 2'd3, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1);
    apply("R10 R11 forced", 2'd3, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1);
    apply("R9 copy zero", 2'd3, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
    apply("R10 forced again", 2'd0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0);
    // R12 collisions
    apply("R12 ovf beats write", 2'd0, 1'b1, 1'b0, 32'h0000_0800, 1'b1, 1'b0, 1'b0);
    apply("R12 both strobes full rules", 2'd0, 1'b1, 1'b1, 32'h0005_0000, 1'b0, 1'b0, 1'b0);
    // R2 reserved bits at lowest privilege
    apply("R2 reserved cpl3", 2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    // R13 several fields in one edge
    apply("R13 same edge", 2'd0, 1'b1, 1'b0, 32'h0006_3A55, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 60; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply("R3 R4 R5 R6 random", lfsr[1:0], lfsr[2], lfsr[3] & lfsr[4],
            {lfsr[12:5], lfsr[31:8]}, lfsr[6] & lfsr[7], lfsr[9], lfsr[10]);
    end

    @(negedge clk);
    wr_full = 1'b0; wr_low = 1'b0; ovf_upd = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule